// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller that paces a successive-approximation converter. An active-low start input launches a conversion. The block holds a busy flag high for a fixed number of clock cycles, which stand in for the bit-decision time. When busy drops, it emits a one-cycle data-valid pulse. Between conversions it sits in an acquisition phase. A conversion that has started always runs to the end. Start activity and power-down requests that arrive during a conversion cannot cut it short or stretch it.

A two-bit mode input selects standard (00), fast (01) or low-power (10) operation. Code 11 behaves as standard. In standard and fast modes, every conversion needs a fresh start request. In low-power mode, a start input still held low at the end of a conversion chains into the next conversion after a minimum acquisition interval, with no new edge needed. In that mode a reduced-power flag is raised while acquiring. A power-down request seen during a conversion is remembered, and the block moves to a powered-down state when busy falls. While powered down, it refuses to start.

Top module: `sar_conv_seq`

## Requirements
- R1: After a synchronous reset, busy, data_valid and pd_down are low, and no conversion begins until start_n is seen low. In that first idle state, a low level on start_n sampled at a rising clock edge makes busy high from that edge onward.
- R2: Each conversion holds busy high for exactly CONV_LEN consecutive cycles (default 16). Every launch produces exactly one completion.
- R3: During a conversion, changes on start_n and pd_req neither shorten nor lengthen it. Low pulses of start_n that begin and end inside a conversion do not queue another conversion.
- R4: data_valid is a one-cycle pulse, high in the first cycle in which busy is low after a conversion.
- R5: In mode 00, mode 01 and mode 11, a further conversion starts only after start_n has been seen high and then low again. Holding start_n low across the end of a conversion starts nothing.
- R6: In mode 10, if start_n is low in the last conversion cycle, the next conversion starts on its own after busy has been low for exactly ACQ_MIN cycles (default 4). Once start_n returns high, the chain stops.
- R7: low_pwr is high while acquiring in mode 10 and while powered down. It is low while busy and while acquiring in the other modes.
- R8: A pd_req pulse seen during a conversion is latched. pd_down is high in the cycle where data_valid pulses. While pd_down is high, no conversion starts. pd_down clears one cycle after pd_req is low.
- R9: A synchronous reset during a conversion drops busy at that edge and discards any latched power-down request. The next conversion then ends without entering power-down.
- R10: The mode input is sampled only outside a conversion. If the mode changes during a low-power conversion, whether that conversion chains into the next one is still decided by low-power rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Active-low convert request |
| mode | input | 2 | 00 standard, 01 fast, 10 low-power, 11 as standard |
| pd_req | input | 1 | Power-down request, active high |
| busy | output | 1 | High for the whole conversion |
| data_valid | output | 1 | One-cycle pulse as busy falls |
| low_pwr | output | 1 | Reduced-power indication |
| pd_down | output | 1 | Block is in the powered-down state |

## Verification
The assertions assume that start_n, pd_req and mode are clean levels, synchronous to clk, and already settled at each rising edge. They also assume that reset is held for at least one edge before any property is relied on. The stimulus changes every input only just after a falling edge, holds it for whole cycles, and releases reset only after several edges. It never toggles start_n while powered down in a way that leaves it low at the release of power-down.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_ACQ  = 2'b01,
      ST_CONV = 2'b10,
      ST_PDN  = 2'b11
   } seq_st_e;

   typedef enum logic [1:0] {
      MD_STD    = 2'b00,
      MD_FAST   = 2'b01,
      MD_LOWPWR = 2'b10,
      MD_RSVD   = 2'b11
   } seq_mode_e;

endpackage

// File: rtl/sar_cyc_timer.sv
module sar_cyc_timer #(
   parameter int LEN = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic en,
   output logic last
);

   generate
      if (LEN <= 1) begin : g_flat
         logic unused_in;
         assign unused_in = ^{clk, rst, clr, en};
         assign last = 1'b1;
      end else begin : g_cnt
         localparam int CW = $clog2(LEN);
         localparam logic [CW-1:0] TOP = CW'(LEN - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst || clr)
               cnt_q <= '0;
            else if (en && !last)
               cnt_q <= cnt_q + 1'b1;
         end

         assign last = (cnt_q == TOP);

         // R2: the count never runs past its terminal value
         p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
            cnt_q <= TOP);
      end
   endgenerate

endmodule

// File: rtl/sar_start_arm.sv
module sar_start_arm (
   input  logic clk,
   input  logic rst,
   input  logic start_n,
   input  logic hold,
   input  logic clr,
   output logic armed
);

   logic armed_q;

   always_ff @(posedge clk) begin
      if (rst || clr)
         armed_q <= 1'b0;
      else if (start_n)
         armed_q <= 1'b1;
      else if (hold)
         armed_q <= 1'b0;
   end

   assign armed = armed_q;

   // R5: a low start level during a conversion leaves nothing armed
   p_hold_disarm_r5: assert property (@(posedge clk) disable iff (rst)
      (hold && !start_n && !clr) |=> !armed_q);

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
   import sar_seq_pkg::*;
#(
   parameter int CONV_LEN = 16,
   parameter int ACQ_MIN  = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       start_n,
   input  logic [1:0] mode,
   input  logic       pd_req,
   output logic       busy,
   output logic       data_valid,
   output logic       low_pwr,
   output logic       pd_down
);

   seq_st_e   st_q, st_d;
   seq_mode_e mode_q;
   logic      auto_q, pd_lat_q, dv_q;
   logic      conv_last, acq_last, armed, launch, conv_end;

   sar_cyc_timer #(.LEN(CONV_LEN)) u_conv_tmr (
      .clk (clk), .rst (rst), .clr (st_q != ST_CONV), .en (1'b1), .last (conv_last)
   );

   sar_cyc_timer #(.LEN(ACQ_MIN)) u_acq_tmr (
      .clk (clk), .rst (rst), .clr (st_q != ST_ACQ), .en (1'b1), .last (acq_last)
   );

   sar_start_arm u_arm (
      .clk (clk), .rst (rst), .start_n (start_n), .hold (st_q == ST_CONV),
      .clr (launch), .armed (armed)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: begin
            if (pd_req)        st_d = ST_PDN;
            else if (!start_n) st_d = ST_CONV;
         end
         ST_ACQ: begin
            if (pd_req)
               st_d = ST_PDN;
            else if ((!start_n && armed) || (auto_q && acq_last))
               st_d = ST_CONV;
         end
         ST_CONV: begin
            if (conv_last) st_d = (pd_lat_q || pd_req) ? ST_PDN : ST_ACQ;
         end
         ST_PDN: begin
            if (!pd_req) st_d = ST_ACQ;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   assign launch   = (st_q != ST_CONV) && (st_d == ST_CONV);
   assign conv_end = (st_q == ST_CONV) && conv_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= ST_IDLE;
         mode_q   <= MD_STD;
         auto_q   <= 1'b0;
         pd_lat_q <= 1'b0;
         dv_q     <= 1'b0;
      end else begin
         st_q     <= st_d;
         dv_q     <= conv_end;
         pd_lat_q <= (st_q == ST_CONV) && !conv_last && (pd_lat_q || pd_req);
         if (st_q != ST_CONV)
            mode_q <= seq_mode_e'(mode);
         if (conv_end)
            auto_q <= (mode_q == MD_LOWPWR) && !start_n && !(pd_lat_q || pd_req);
         else if (launch || start_n || st_q == ST_PDN)
            auto_q <= 1'b0;
      end
   end

   assign busy       = (st_q == ST_CONV);
   assign data_valid = dv_q;
   assign pd_down    = (st_q == ST_PDN);
   assign low_pwr    = ((st_q == ST_ACQ) && (mode_q == MD_LOWPWR)) || (st_q == ST_PDN);

   // R1: idle with start high stays quiet
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_IDLE && start_n) |=> !busy);

   // R3: a running conversion is never cut before its last cycle
   p_no_abort_r3: assert property (@(posedge clk) disable iff (rst)
      (busy && !conv_last) |=> busy);

   // R4: completion pulse coincides with busy falling and lasts one cycle
   p_dv_fall_r4: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> data_valid);
   p_dv_single_r4: assert property (@(posedge clk) disable iff (rst)
      data_valid |=> !data_valid);

   // R6: a chained restart never comes before the acquisition minimum
   p_auto_gap_r6: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_ACQ && auto_q && !acq_last && start_n) |=> !busy);

   // R7: the reduced-power flag is never raised while converting
   p_lp_busy_r7: assert property (@(posedge clk) disable iff (rst)
      busy |-> !low_pwr);

   // R8: no conversion follows a powered-down cycle directly
   p_pd_nostart_r8: assert property (@(posedge clk) disable iff (rst)
      pd_down |=> !busy);

endmodule

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb_top;

   localparam int CONV_LEN = 16;
   localparam int ACQ_MIN  = 4;

   typedef struct {
      int gap;
      bit pd;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst;
   logic       start_n;
   logic [1:0] mode;
   logic       pd_req;
   logic       busy, data_valid, low_pwr, pd_down;

   int   total = 0;
   int   bad   = 0;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   sar_conv_seq #(.CONV_LEN(CONV_LEN), .ACQ_MIN(ACQ_MIN)) dut_i (
      .clk (clk), .rst (rst), .start_n (start_n), .mode (mode), .pd_req (pd_req),
      .busy (busy), .data_valid (data_valid), .low_pwr (low_pwr), .pd_down (pd_down)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_dv();
      do @(negedge clk); while (!data_valid);
   endtask

   task automatic push(input int gap, input bit pd);
      exp_t e;
      e.gap = gap;
      e.pd  = pd;
      exp_q.push_back(e);
   endtask

   // monitor: measures every conversion and compares with the scoreboard
   int blen = 0, gap = 0, last_gap = 0;
   bit prev_busy = 1'b0;
   always @(negedge clk) begin
      if (rst) begin
         blen = 0; gap = 0; last_gap = 0; prev_busy = 1'b0;
      end else begin
         if (busy) begin
            if (!prev_busy) last_gap = gap;
            blen++;
            if (low_pwr) chk(1'b0, "R7 low_pwr while busy", 1, 0);
         end else begin
            gap++;
         end
         if (data_valid) begin
            chk(!busy && prev_busy, "R4 data_valid timing", int'(busy), 0);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected conversion", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(blen == CONV_LEN, "R2 busy length", blen, CONV_LEN);
               chk(pd_down == e.pd, "R8 pd_down at completion", int'(pd_down), int'(e.pd));
               if (e.gap >= 0)
                  chk(last_gap == e.gap, "R6 acquisition gap", last_gap, e.gap);
            end
            blen = 0;
            gap  = 1;
         end
         prev_busy = busy;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1; start_n = 1'b1; mode = 2'b00; pd_req = 1'b0;
      cyc(3);
      rst = 1'b0;
      cyc(10);
      chk(busy == 1'b0, "R1 idle busy", int'(busy), 0);
      chk(pd_down == 1'b0, "R1 idle pd_down", int'(pd_down), 0);

      // R1 first start, R3 pulses inside the conversion
      push(-1, 1'b0);
      start_n = 1'b0;
      cyc(1);
      chk(busy == 1'b1, "R1 start level", int'(busy), 1);
      start_n = 1'b1; cyc(3);
      start_n = 1'b0; cyc(2);
      start_n = 1'b1; cyc(2);
      start_n = 1'b0;
      wait_dv();
      cyc(25);
      chk(busy == 1'b0, "R3 no queued start", int'(busy), 0);

      // R5 standard mode needs high then low
      start_n = 1'b1; cyc(1);
      start_n = 1'b0;
      push(-1, 1'b0);
      cyc(1);
      chk(busy == 1'b1, "R5 rearmed start", int'(busy), 1);
      start_n = 1'b1;
      wait_dv();

      // R5 fast mode, held low
      mode = 2'b01; cyc(2);
      start_n = 1'b0;
      push(-1, 1'b0);
      wait_dv();
      cyc(25);
      chk(busy == 1'b0, "R5 fast mode no restart", int'(busy), 0);

      // R6 low-power chaining
      mode = 2'b10; start_n = 1'b1; cyc(2);
      push(-1, 1'b0); push(ACQ_MIN, 1'b0); push(ACQ_MIN, 1'b0);
      start_n = 1'b0;
      wait_dv();
      wait_dv();
      cyc(5);
      start_n = 1'b1;
      wait_dv();
      cyc(3);
      chk(low_pwr == 1'b1, "R7 low_pwr acquiring", int'(low_pwr), 1);
      cyc(20);
      chk(busy == 1'b0, "R6 chain stops", int'(busy), 0);

      // R10 mode change inside a low-power conversion
      start_n = 1'b0;
      push(-1, 1'b0); push(ACQ_MIN, 1'b0);
      cyc(5);
      mode = 2'b00;
      wait_dv();
      wait_dv();
      cyc(25);
      chk(busy == 1'b0, "R10 standard after switch", int'(busy), 0);
      chk(low_pwr == 1'b0, "R7 low_pwr standard", int'(low_pwr), 0);

      // R8 pulse latched
      start_n = 1'b1; cyc(2);
      start_n = 1'b0;
      push(-1, 1'b1);
      cyc(1);
      start_n = 1'b1; cyc(4);
      pd_req = 1'b1; cyc(1);
      pd_req = 1'b0;
      wait_dv();
      cyc(1);
      chk(pd_down == 1'b0, "R8 pd release", int'(pd_down), 0);

      // R8 held request blocks starts
      start_n = 1'b0;
      push(-1, 1'b1);
      cyc(1);
      start_n = 1'b1; cyc(6);
      pd_req = 1'b1;
      wait_dv();
      cyc(2);
      chk(pd_down == 1'b1, "R8 powered down", int'(pd_down), 1);
      chk(low_pwr == 1'b1, "R7 low_pwr powered down", int'(low_pwr), 1);
      start_n = 1'b0; cyc(3);
      start_n = 1'b1; cyc(5);
      chk(busy == 1'b0, "R8 start refused", int'(busy), 0);
      pd_req = 1'b0; cyc(2);
      chk(pd_down == 1'b0, "R8 left power-down", int'(pd_down), 0);
      start_n = 1'b0;
      push(-1, 1'b0);
      cyc(1);
      chk(busy == 1'b1, "R8 start after release", int'(busy), 1);
      start_n = 1'b1;
      wait_dv();

      // R9 reset during a conversion with a latched request
      cyc(2);
      start_n = 1'b0; cyc(1);
      start_n = 1'b1; cyc(4);
      pd_req = 1'b1; cyc(1);
      pd_req = 1'b0; cyc(2);
      rst = 1'b1; cyc(1);
      chk(busy == 1'b0, "R9 reset drops busy", int'(busy), 0);
      cyc(1);
      rst = 1'b0;
      cyc(30);
      chk(busy == 1'b0, "R9 idle after reset", int'(busy), 0);
      chk(pd_down == 1'b0, "R9 no power-down", int'(pd_down), 0);
      push(-1, 1'b0);
      start_n = 1'b0; cyc(1);
      start_n = 1'b1;
      wait_dv();
      cyc(5);

      chk(exp_q.size() == 0, "R2 all conversions done", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule